// File: doc/BRIEF.md
# Sum-of-Products Logic Array with Tristate Output Cells

This block is a soft, reconfigurable two-level logic array. Sixteen array signals drive an AND plane. Ten of them come from dedicated inputs and six come from the sensed values of shared bidirectional pins. Each of the eight output cells owns nine product terms. Eight of these feed a fixed OR gate. The ninth drives the cell's output enable. A polarity bit then selects whether the cell delivers the OR result or its complement.

Configuration is a single long shift chain, loaded one bit per clock while a load strobe is high. The array path itself is purely combinational, from the inputs and the configuration to the outputs. Each pin is modelled as a value and enable pair. Output cells 0 to 5 pair with shared pins 0 to 5. The surrounding pad logic returns the resolved pin level on `io_in`. When a cell's enable is low, an external driver on that pin therefore acts as an ordinary array input.

Top module: `pal_array`

## Requirements
- R1: Reset clears every configuration bit to 0, so all connections are intact, every product term is 0 and `out_oe` is all zero. Until the first load, no enable rises.
- R2: While `cfg_en` is high, each rising clock edge shifts `cfg_bit` into bit 0 and moves every bit up one place. After 2312 shifts, the first bit sent sits at the top index, 2311. While `cfg_en` is low, the chain holds and `cfg_bit` has no effect on the outputs.
- R3: Array signal j is `ded_in[j]` for j 0..9 and `io_in[j-10]` for j 10..15. Within a term's 32-bit row, bit 2j controls the true literal and bit 2j+1 controls the inverted literal. A value of 0 means connected and 1 means removed. A term is 1 exactly when every connected literal is 1. A row with every bit removed gives 1, and a row connecting both literals of one signal gives 0.
- R4: Term t of cell o uses configuration bits [(o*9+t)*32 +: 32]. The cell's OR takes terms t = 0..7 and no others. Term 8 never reaches the sum.
- R5: Bit 2304+o is the polarity bit of cell o. When it is 0, `out_val[o]` equals the OR result. When it is 1, `out_val[o]` is the complement.
- R6: `out_oe[o]` equals term 8 of cell o.
- R7: The value on `io_in` enters the array in the same cycle. An externally driven level on a disabled shared pin changes the terms that use it.

Outputs follow the inputs combinationally, with no register in the array path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Load strobe; shift one configuration bit per edge |
| cfg_bit | input | 1 | Serial configuration data |
| ded_in | input | 10 | Dedicated array inputs |
| io_in | input | 6 | Sensed level of the shared pins |
| out_val | output | 8 | Output cell values |
| out_oe | output | 8 | Output cell tristate enables |

## Verification
A single input change can alter a cell's sum and the enables of several cells in the same cycle. In one vector, dedicated input 9 switches cell 0 on and cell 6 off, while shared pin 0 feeds the sum of cell 0 itself. That vector, and its neighbours, are judged by comparing the full value and enable vectors against hand-derived expected values. A separate load places a single 1 as the first bit shifted. This exposes the shift order through the polarity of cell 7.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int DEF_DED = 10;
  localparam int DEF_IO  = 6;
  localparam int DEF_OUT = 8;
  localparam int DEF_SUM = 8;

  // One literal pair: a removed connection (1) never pulls the AND low.
  function automatic logic lit_pass(logic cut_true, logic cut_inv, logic x);
    return (cut_true | x) & (cut_inv | ~x);
  endfunction

  // First configuration bit of term t in cell o.
  function automatic int row_base(int o, int t, int terms, int cols);
    return (o * terms + t) * cols;
  endfunction
endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
  parameter int W = 2312
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  output logic [W-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= {cfg_q[W-2:0], cfg_bit};
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_q)); // R2
  AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_q[0] == $past(cfg_bit)) && (cfg_q[W-1:1] == $past(cfg_q[W-2:0]))); // R2
endmodule

// File: rtl/pal_product.sv
module pal_product #(
  parameter int N_IN = 16
) (
  input  logic [2*N_IN-1:0] row,
  input  logic [N_IN-1:0]   x,
  output logic              term
);
  import pal_pkg::*;
  logic [N_IN-1:0] pass;

  for (genvar j = 0; j < N_IN; j++) begin : g_col
    assign pass[j] = lit_pass(row[2*j], row[2*j+1], x[j]);
  end
  assign term = &pass;

  always_comb begin
    if (&row) AST_ALL_CUT: assert (term); // R3
  end
endmodule

// File: rtl/pal_cell.sv
module pal_cell #(
  parameter int N_IN  = 16,
  parameter int N_SUM = 8
) (
  input  logic [(N_SUM+1)*2*N_IN-1:0] rows,
  input  logic [N_IN-1:0]             x,
  input  logic                        pol_cut,
  output logic                        val,
  output logic                        oe
);
  localparam int COLS  = 2 * N_IN;
  localparam int TERMS = N_SUM + 1;

  logic [TERMS-1:0] terms;
  logic             sum_or;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    pal_product #(.N_IN(N_IN)) u_pt (
      .row  (rows[t*COLS +: COLS]),
      .x    (x),
      .term (terms[t])
    );
  end

  assign sum_or = |terms[N_SUM-1:0];
  assign oe     = terms[N_SUM];
  assign val    = pol_cut ? ~sum_or : sum_or;

  always_comb begin
    if (!pol_cut && terms[0]) AST_OR_FLOOR: assert (val); // R4
  end
endmodule

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_DED = pal_pkg::DEF_DED,
  parameter int N_IO  = pal_pkg::DEF_IO,
  parameter int N_OUT = pal_pkg::DEF_OUT,
  parameter int N_SUM = pal_pkg::DEF_SUM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_IO-1:0]  io_in,
  output logic [N_OUT-1:0] out_val,
  output logic [N_OUT-1:0] out_oe
);
  localparam int N_IN   = N_DED + N_IO;
  localparam int COLS   = 2 * N_IN;
  localparam int TERMS  = N_SUM + 1;
  localparam int CELL_W = TERMS * COLS;
  localparam int ARR_W  = N_OUT * CELL_W;
  localparam int CFG_W  = ARR_W + N_OUT;

  logic [CFG_W-1:0] cfg_q;
  logic [N_IN-1:0]  arr_x;
  logic             cfg_touched;

  pal_cfg_chain #(.W(CFG_W)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .cfg_q   (cfg_q)
  );

  // Shared pins enter the array from their sensed level.
  assign arr_x = {io_in, ded_in};

  for (genvar o = 0; o < N_OUT; o++) begin : g_cell
    pal_cell #(.N_IN(N_IN), .N_SUM(N_SUM)) u_cell (
      .rows    (cfg_q[o*CELL_W +: CELL_W]),
      .x       (arr_x),
      .pol_cut (cfg_q[ARR_W+o]),
      .val     (out_val[o]),
      .oe      (out_oe[o])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_touched <= 1'b0;
    else if (cfg_en) cfg_touched <= 1'b1;
  end

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_touched |-> (out_oe == '0)); // R1
  AST_SENSE_ONLY_WHEN_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_touched |-> (out_val == '0)); // R1
endmodule

// File: tb/pal_array_test.sv
module pal_array_test;
  localparam int CFG_W = 2312;
  localparam int COLS  = 32;
  localparam int TERMS = 9;
  localparam int POL0  = 2304;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_bit = 1'b0;
  logic [9:0] ded_in = '0;
  logic [5:0] io_in = '0;
  logic [7:0] out_val, out_oe;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [CFG_W-1:0] img;

  // {ded_in, io_in, expected out_val, expected out_oe} under configuration A
  localparam logic [31:0] VEC [6] = '{
    {10'h000, 6'h00, 8'h02, 8'h42},
    {10'h003, 6'h00, 8'h03, 8'h42},
    {10'h208, 6'h01, 8'h01, 8'h03},
    {10'h010, 6'h20, 8'h02, 8'h42},
    {10'h000, 6'h20, 8'h42, 8'h42},
    {10'h004, 6'h01, 8'h02, 8'h42}
  };

  pal_array uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .ded_in(ded_in), .io_in(io_in), .out_val(out_val), .out_oe(out_oe)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Row for term t of cell o: listed signals connected, all else removed.
  task automatic set_term(int o, int t, logic [15:0] tmask, logic [15:0] imask);
    int base = (o * TERMS + t) * COLS;
    for (int j = 0; j < 16; j++) begin
      img[base + 2*j]     = ~tmask[j];
      img[base + 2*j + 1] = ~imask[j];
    end
  endtask

  task automatic load();
    for (int i = CFG_W - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_bit = img[i];
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_bit = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset oe", out_oe, 8'h00);
    check("R1 reset val", out_val, 8'h00);

    // Configuration A
    img = '0;
    set_term(0, 0, 16'h0003, 16'h0000);
    set_term(0, 1, 16'h0400, 16'h0004);
    set_term(0, 8, 16'h0200, 16'h0000);
    set_term(1, 0, 16'h0008, 16'h0000);
    set_term(1, 8, 16'h0000, 16'h0000);
    img[POL0 + 1] = 1'b1;
    set_term(6, 0, 16'h8000, 16'h0010);
    set_term(6, 8, 16'h0000, 16'h0200);
    load();

    for (int v = 0; v < 6; v++) begin
      ded_in = VEC[v][31:22];
      io_in  = VEC[v][21:16];
      @(negedge clk);
      check($sformatf("R3/R5/R7 vec%0d val", v), out_val, VEC[v][15:8]);
      check($sformatf("R6/R7 vec%0d oe", v), out_oe, VEC[v][7:0]);
    end

    // R7: disabled shared pin 5 driven externally flips cell 6 sum
    ded_in = 10'h000; io_in = 6'h00;
    @(negedge clk);
    check("R7 pin low", out_val & 8'h40, 8'h00);
    io_in = 6'h20;
    @(negedge clk);
    check("R7 pin high", out_val & 8'h40, 8'h40);

    // R1: reset clears a loaded configuration
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset after load oe", out_oe, 8'h00);
    check("R1 reset after load val", out_val, 8'h00);

    // Configuration B: all-removed rows, contradictory row, enable isolation
    img = '0;
    set_term(2, 3, 16'h0000, 16'h0000);
    set_term(2, 8, 16'h0000, 16'h0000);
    set_term(3, 8, 16'h0000, 16'h0000);
    set_term(4, 0, 16'h0001, 16'h0001);
    set_term(4, 8, 16'h0000, 16'h0000);
    load();
    ded_in = 10'h000; io_in = 6'h00;
    @(negedge clk);
    check("R3/R4 cfgB pattern0 val", out_val, 8'h04);
    check("R6 cfgB pattern0 oe", out_oe, 8'h1C);
    ded_in = 10'h3FF; io_in = 6'h3F;
    @(negedge clk);
    check("R3/R4 cfgB pattern1 val", out_val, 8'h04);
    check("R6 cfgB pattern1 oe", out_oe, 8'h1C);

    // R2 shift order: first bit lands on the top index (cell 7 polarity)
    img = '0;
    img[CFG_W - 1] = 1'b1;
    load();
    ded_in = 10'h000; io_in = 6'h00;
    @(negedge clk);
    check("R2 order val", out_val, 8'h80);
    check("R5 inverted empty sum oe", out_oe, 8'h00);

    // R2 hold: cfg_bit toggling without cfg_en has no effect
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfg_bit = ~cfg_bit;
    end
    @(negedge clk);
    check("R2 hold val", out_val, 8'h80);
    check("R2 hold oe", out_oe, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule